// File: doc/BRIEF.md
# Lookahead Stride Prefetch Predictor

This block learns a constant address stride for each load instruction and turns that knowledge into early prefetch requests. Every committed load presents its program counter and data address. The block keeps a small direct-mapped table. Each table slot holds a PC tag, the last address seen, the current stride guess and a two-bit confidence state. A correct stride guess raises confidence and a wrong one lowers it.

Prefetch lookups do not come from the committing load. A separate lookahead PC, which an external branch-prediction path runs ahead of the real instruction stream, probes the table. If the probed slot is confident, the block forms the next address, which is the last address plus the stride, and aligns it to a cache line. It then offers that address on a valid/ready request port. The block records every line it has requested in a small outstanding list. A line stays there until a completion names it again, so no line is requested twice while it is in flight. When that list is full, new candidates are dropped.

Top module: `stride_prefetcher`

Confidence states: INIT, TRANSIENT, STEADY and NO_PRED. A commit that matches the stored stride moves INIT to STEADY, TRANSIENT to STEADY and NO_PRED to TRANSIENT, and leaves STEADY in STEADY. A commit that does not match the stored stride behaves as follows: STEADY goes to INIT and keeps its stride; INIT goes to TRANSIENT, TRANSIENT goes to NO_PRED and NO_PRED stays in NO_PRED, and each of these three takes the new delta as its stride. The request port has two states. ISSUE_IDLE moves to ISSUE_HOLD when a candidate is accepted, and ISSUE_HOLD moves back to ISSUE_IDLE on the handshake.

## Requirements
- R1: After reset no request is pending, every table slot is empty and the outstanding list is empty.
- R2: A commit whose PC misses in the table overwrites the slot. The new contents are the new tag, the address as last address, a stride of zero and state INIT.
- R3: A commit whose PC hits in the table always updates the last address. The state and the stride follow the confidence transitions listed above, where "correct" means the new address minus the last address equals the stored stride.
- R4: A lookahead probe yields a candidate only when the probed slot is valid, its tag matches and its state is STEADY.
- R5: The requested address is the last address plus the stride, with the low LINE_BITS bits cleared (64-byte lines by default).
- R6: Once raised, pf_valid stays high and pf_addr stays unchanged until pf_ready is seen. Probes that arrive while a request is pending are dropped.
- R7: A candidate whose line is already in the outstanding list is not requested.
- R8: A completion (done_valid with done_addr) frees the outstanding entry holding the same line, and that line can be requested again afterwards.
- R9: When all OL_DEPTH outstanding entries (default 4) are in use, new candidates are dropped.
- R10: The table index is PC bits [IDX_W+1:2] (PC[5:2] by default) and the tag is the PC bits above them. PCs with the same index but different tags evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| commit_valid | input | 1 | A load commits this cycle |
| commit_pc | input | PC_W | PC of the committing load |
| commit_addr | input | ADDR_W | Data address of the committing load |
| la_valid | input | 1 | Lookahead PC is valid this cycle |
| la_pc | input | PC_W | Lookahead PC from the branch-prediction path |
| pf_valid | output | 1 | Prefetch request pending |
| pf_ready | input | 1 | Consumer accepts the request |
| pf_addr | output | ADDR_W | Line-aligned prefetch address |
| done_valid | input | 1 | A prefetch completed |
| done_addr | input | ADDR_W | Any address inside the completed line |

## Verification
The bench drives each confidence transition and probes after each step. A design that skipped TRANSIENT, or that cleared the stride when STEADY fails, would issue a request too early or at the wrong address. It also checks that a stride of zero after allocation can reach STEADY, and that an aliasing PC evicts its neighbour. It fills the outstanding list to the last slot, re-probes a line already in flight and frees a line before asking for it again. A filter off by one entry, or one that frees nothing, would show as an extra or a missing request. The bench also holds pf_ready low for several cycles, so an address that moved or a valid that dropped early is caught.

// File: rtl/spf_pkg.sv
package spf_pkg;
    typedef enum logic [1:0] {
        CONF_INIT   = 2'd0,
        CONF_TRANS  = 2'd1,
        CONF_STEADY = 2'd2,
        CONF_NOPRED = 2'd3
    } conf_e;

    typedef enum logic {
        ISSUE_IDLE = 1'b0,
        ISSUE_HOLD = 1'b1
    } issue_e;
endpackage

// File: rtl/spf_conf_fsm.sv
module spf_conf_fsm
    import spf_pkg::*;
(
    input  conf_e cur_state,
    input  logic  stride_ok,
    output conf_e nxt_state,
    output logic  take_delta
);
    always_comb begin
        nxt_state  = cur_state;
        take_delta = 1'b0;
        unique case (cur_state)
            CONF_INIT: begin
                nxt_state  = stride_ok ? CONF_STEADY : CONF_TRANS;
                take_delta = !stride_ok;
            end
            CONF_TRANS: begin
                nxt_state  = stride_ok ? CONF_STEADY : CONF_NOPRED;
                take_delta = !stride_ok;
            end
            CONF_STEADY: begin
                nxt_state  = stride_ok ? CONF_STEADY : CONF_INIT;
            end
            CONF_NOPRED: begin
                nxt_state  = stride_ok ? CONF_TRANS : CONF_NOPRED;
                take_delta = !stride_ok;
            end
        endcase
    end
endmodule

// File: rtl/spf_table.sv
module spf_table
    import spf_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [PC_W-1:0]   wr_pc,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PC_W-1:0]   rd_pc,
    output logic              rd_hit,
    output conf_e             rd_conf,
    output logic [ADDR_W-1:0] rd_pred
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int TAG_W = PC_W - IDX_W - 2;

    logic              vld_q    [DEPTH];
    logic [TAG_W-1:0]  tag_q    [DEPTH];
    logic [ADDR_W-1:0] prev_q   [DEPTH];
    logic [ADDR_W-1:0] stride_q [DEPTH];
    conf_e             conf_q   [DEPTH];

    logic [IDX_W-1:0]  w_idx, r_idx;
    logic [TAG_W-1:0]  w_tag, r_tag;
    logic              w_hit, w_ok, w_take;
    logic [ADDR_W-1:0] w_delta;
    conf_e             w_next;

    assign w_idx   = wr_pc[IDX_W+1:2];
    assign w_tag   = wr_pc[PC_W-1:IDX_W+2];
    assign w_hit   = vld_q[w_idx] && (tag_q[w_idx] == w_tag);
    assign w_delta = wr_addr - prev_q[w_idx];
    assign w_ok    = (w_delta == stride_q[w_idx]);

    spf_conf_fsm i_conf (
        .cur_state (conf_q[w_idx]),
        .stride_ok (w_ok),
        .nxt_state (w_next),
        .take_delta(w_take)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                vld_q[i]    <= 1'b0;
                tag_q[i]    <= '0;
                prev_q[i]   <= '0;
                stride_q[i] <= '0;
                conf_q[i]   <= CONF_INIT;
            end
        end else if (wr_valid) begin
            prev_q[w_idx] <= wr_addr;
            if (w_hit) begin
                conf_q[w_idx] <= w_next;
                if (w_take) stride_q[w_idx] <= w_delta;
            end else begin
                vld_q[w_idx]    <= 1'b1;
                tag_q[w_idx]    <= w_tag;
                stride_q[w_idx] <= '0;
                conf_q[w_idx]   <= CONF_INIT;
            end
        end
    end

    assign r_idx   = rd_pc[IDX_W+1:2];
    assign r_tag   = rd_pc[PC_W-1:IDX_W+2];
    assign rd_hit  = vld_q[r_idx] && (tag_q[r_idx] == r_tag);
    assign rd_conf = conf_q[r_idx];
    assign rd_pred = prev_q[r_idx] + stride_q[r_idx];
endmodule

// File: rtl/spf_olist.sv
module spf_olist #(
    parameter int LINE_W = 26,
    parameter int DEPTH  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [LINE_W-1:0]            query_line,
    output logic                         present,
    output logic                         full,
    input  logic                         alloc,
    input  logic                         release_en,
    input  logic [LINE_W-1:0]            release_line,
    output logic [DEPTH-1:0]             vld_o,
    output logic [DEPTH-1:0][LINE_W-1:0] lines_o,
    output logic [$clog2(DEPTH+1)-1:0]   cnt_o
);
    localparam int SLOT_W = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic [DEPTH-1:0]             vld_q;
    logic [DEPTH-1:0][LINE_W-1:0] line_q;
    logic [DEPTH-1:0]             hit_vec;
    logic [SLOT_W-1:0]            free_slot;

    for (genvar g = 0; g < DEPTH; g++) begin : g_match
        assign hit_vec[g] = vld_q[g] && (line_q[g] == query_line);
    end

    always_comb begin
        free_slot = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld_q[i]) free_slot = SLOT_W'(i);
        end
    end

    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < DEPTH; i++) cnt_o = cnt_o + CNT_W'(vld_q[i]);
    end

    assign present = |hit_vec;
    assign full    = &vld_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            line_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (release_en && vld_q[i] && (line_q[i] == release_line)) vld_q[i] <= 1'b0;
            end
            if (alloc) begin
                vld_q[free_slot]  <= 1'b1;
                line_q[free_slot] <= query_line;
            end
        end
    end

    assign vld_o   = vld_q;
    assign lines_o = line_q;
endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher
    import spf_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int ADDR_W    = 32,
    parameter int TBL_DEPTH = 16,
    parameter int OL_DEPTH  = 4,
    parameter int LINE_BITS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_valid,
    input  logic [PC_W-1:0]   commit_pc,
    input  logic [ADDR_W-1:0] commit_addr,
    input  logic              la_valid,
    input  logic [PC_W-1:0]   la_pc,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr,
    input  logic              done_valid,
    input  logic [ADDR_W-1:0] done_addr
);
    localparam int LINE_W = ADDR_W - LINE_BITS;
    localparam int CNT_W  = $clog2(OL_DEPTH + 1);

    issue_e                         state_q, state_d;
    logic                           probe_hit;
    conf_e                          probe_conf;
    logic [ADDR_W-1:0]              probe_pred;
    logic [LINE_W-1:0]              cand_line;
    logic                           cand_ok, in_flight, ol_full, fire;
    logic [LINE_W-1:0]              line_q;
    logic [OL_DEPTH-1:0]            ol_vld;
    logic [OL_DEPTH-1:0][LINE_W-1:0] ol_lines;
    logic [CNT_W-1:0]               ol_cnt;

    spf_table #(.PC_W(PC_W), .ADDR_W(ADDR_W), .DEPTH(TBL_DEPTH)) i_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_valid(commit_valid),
        .wr_pc   (commit_pc),
        .wr_addr (commit_addr),
        .rd_pc   (la_pc),
        .rd_hit  (probe_hit),
        .rd_conf (probe_conf),
        .rd_pred (probe_pred)
    );

    assign cand_line = probe_pred[ADDR_W-1:LINE_BITS];
    assign cand_ok   = la_valid && probe_hit && (probe_conf == CONF_STEADY);
    assign fire      = (state_q == ISSUE_IDLE) && cand_ok && !in_flight && !ol_full;

    spf_olist #(.LINE_W(LINE_W), .DEPTH(OL_DEPTH)) i_olist (
        .clk         (clk),
        .rst_n       (rst_n),
        .query_line  (cand_line),
        .present     (in_flight),
        .full        (ol_full),
        .alloc       (fire),
        .release_en  (done_valid),
        .release_line(done_addr[ADDR_W-1:LINE_BITS]),
        .vld_o       (ol_vld),
        .lines_o     (ol_lines),
        .cnt_o       (ol_cnt)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ISSUE_IDLE: if (fire)     state_d = ISSUE_HOLD;
            ISSUE_HOLD: if (pf_ready) state_d = ISSUE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ISSUE_IDLE;
            line_q  <= '0;
        end else begin
            state_q <= state_d;
            if (fire) line_q <= cand_line;
        end
    end

    always_comb begin
        pf_valid = (state_q == ISSUE_HOLD);
        pf_addr  = {line_q, {LINE_BITS{1'b0}}};
    end
endmodule

// File: rtl/spf_checker.sv
module spf_checker #(
    parameter int ADDR_W    = 32,
    parameter int OL_DEPTH  = 4,
    parameter int LINE_BITS = 6
) (
    input logic                                      clk,
    input logic                                      rst_n,
    input logic                                      pf_valid,
    input logic                                      pf_ready,
    input logic [ADDR_W-1:0]                         pf_addr,
    input logic [OL_DEPTH-1:0]                       ol_vld,
    input logic [OL_DEPTH-1:0][ADDR_W-LINE_BITS-1:0] ol_lines,
    input logic [$clog2(OL_DEPTH+1)-1:0]             ol_cnt
);
    logic dup;
    always_comb begin
        dup = 1'b0;
        for (int i = 0; i < OL_DEPTH; i++)
            for (int j = i + 1; j < OL_DEPTH; j++)
                if (ol_vld[i] && ol_vld[j] && (ol_lines[i] == ol_lines[j])) dup = 1'b1;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!pf_valid && ol_cnt == '0));

    assert_hold_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

    assert_no_dup_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dup);

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_valid) |-> ($past(ol_cnt) < OL_DEPTH));
endmodule

bind stride_prefetcher spf_checker #(
    .ADDR_W(ADDR_W), .OL_DEPTH(OL_DEPTH), .LINE_BITS(LINE_BITS)
) i_spf_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .pf_valid(pf_valid),
    .pf_ready(pf_ready),
    .pf_addr (pf_addr),
    .ol_vld  (ol_vld),
    .ol_lines(ol_lines),
    .ol_cnt  (ol_cnt)
);

// File: tb/test_stride_prefetcher.sv
module test_stride_prefetcher;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        commit_valid = 1'b0;
    logic [31:0] commit_pc = '0;
    logic [31:0] commit_addr = '0;
    logic        la_valid = 1'b0;
    logic [31:0] la_pc = '0;
    logic        pf_valid;
    logic        pf_ready = 1'b0;
    logic [31:0] pf_addr;
    logic        done_valid = 1'b0;
    logic [31:0] done_addr = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    localparam logic [31:0] PC_P = 32'h0000_0400;
    localparam logic [31:0] PC_Q = 32'h0000_0404;
    localparam logic [31:0] PC_R = 32'h0000_0800;

    always #(CLK_PERIOD/2) clk = ~clk;

    stride_prefetcher i_stride_prefetcher (
        .clk(clk), .rst_n(rst_n),
        .commit_valid(commit_valid), .commit_pc(commit_pc), .commit_addr(commit_addr),
        .la_valid(la_valid), .la_pc(la_pc),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
        .done_valid(done_valid), .done_addr(done_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_commit(input logic [31:0] pc, input logic [31:0] addr);
        @(negedge clk);
        commit_valid = 1'b1; commit_pc = pc; commit_addr = addr;
        @(negedge clk);
        commit_valid = 1'b0;
    endtask

    task automatic do_probe(input logic [31:0] pc);
        @(negedge clk);
        la_valid = 1'b1; la_pc = pc;
        @(negedge clk);
        la_valid = 1'b0;
    endtask

    task automatic do_accept();
        @(negedge clk);
        pf_ready = 1'b1;
        @(negedge clk);
        pf_ready = 1'b0;
    endtask

    task automatic do_done(input logic [31:0] addr);
        @(negedge clk);
        done_valid = 1'b1; done_addr = addr;
        @(negedge clk);
        done_valid = 1'b0;
    endtask

    task automatic expect_req(input string req, input logic [31:0] addr);
        chk({req, " pf_valid"}, 32'(pf_valid), 32'd1);
        chk({req, " pf_addr"}, pf_addr, addr);
    endtask

    task automatic expect_none(input string req);
        chk({req, " no request"}, 32'(pf_valid), 32'd0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_none("R1 reset");
        do_probe(PC_P);
        expect_none("R1 empty table");
    endtask

    task automatic t_train_and_hold();
        do_commit(PC_P, 32'h1010);
        do_commit(PC_P, 32'h1110);
        do_probe(PC_P);
        expect_none("R3 TRANSIENT no issue");
        do_commit(PC_P, 32'h1210);
        do_probe(PC_P);
        expect_req("R4 R5 STEADY issue", 32'h1300);
        repeat (3) @(negedge clk);
        expect_req("R6 held without ready", 32'h1300);
        do_accept();
        expect_none("R6 cleared after handshake");
    endtask

    task automatic t_filter_and_free();
        do_probe(PC_P);
        expect_none("R7 duplicate line filtered");
        do_done(32'h1320);
        do_probe(PC_P);
        expect_req("R8 reissue after completion", 32'h1300);
        do_accept();
    endtask

    task automatic t_full_list();
        for (int k = 0; k < 3; k++) begin
            do_commit(PC_P, 32'h1310 + 32'(k) * 32'h100);
            do_probe(PC_P);
            expect_req("R4 stride advance", 32'h1400 + 32'(k) * 32'h100);
            do_accept();
        end
        do_commit(PC_P, 32'h1610);
        do_probe(PC_P);
        expect_none("R9 list full drop");
        do_done(32'h1300);
        do_probe(PC_P);
        expect_req("R8 R9 issue after free", 32'h1700);
        do_accept();
    endtask

    task automatic t_steady_miss();
        for (int k = 0; k < 4; k++) do_done(32'h1400 + 32'(k) * 32'h100);
        do_commit(PC_P, 32'h9000);
        do_probe(PC_P);
        expect_none("R3 STEADY wrong to INIT");
        do_commit(PC_P, 32'h9100);
        do_probe(PC_P);
        expect_req("R3 INIT kept stride to STEADY", 32'h9200);
        do_accept();
        do_done(32'h9200);
    endtask

    task automatic t_nopred_path();
        do_commit(PC_Q, 32'h2000);
        do_commit(PC_Q, 32'h2040);
        do_commit(PC_Q, 32'h2100);
        do_probe(PC_Q);
        expect_none("R3 NO_PRED no issue");
        do_commit(PC_Q, 32'h21C0);
        do_probe(PC_Q);
        expect_none("R3 NO_PRED to TRANSIENT no issue");
        do_commit(PC_Q, 32'h2280);
        do_probe(PC_Q);
        expect_req("R3 R10 TRANSIENT to STEADY", 32'h2340);
        do_accept();
        do_done(32'h2340);
    endtask

    task automatic t_alias();
        do_commit(PC_R, 32'h5000);
        do_probe(PC_P);
        expect_none("R10 alias evicted");
        do_probe(PC_R);
        expect_none("R2 new slot INIT");
        do_commit(PC_R, 32'h5000);
        do_probe(PC_R);
        expect_req("R2 zero stride on allocation", 32'h5000);
        do_accept();
        do_done(32'h5000);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_train_and_hold();
        t_filter_and_free();
        t_full_list();
        t_steady_miss();
        t_nopred_path();
        t_alias();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end
endmodule